// File: doc/BRIEF.md
# Triggered Ring Acquisition Buffer

This block takes a stream of 8-bit converter samples and writes them into a circular store. No write address enters the block. The store's position is a counter of write slots, and that counter returns to zero when an arm command is given. The memory clock runs at half the sample rate. On each valid memory-clock cycle the block therefore accepts two samples: an earlier one on `samp_lo` and a later one on `samp_hi`. These go into an even/odd pair of ring slots.

Writing continues around the ring until the selected trigger input is true. One of four digital trigger levels can be selected: channel one, channel two, an inter-module trigger, or an external trigger. A trigger counts only once enough samples have been written since arm for the record to hold no stale data. After a counted trigger, a programmed number of further samples is stored. Then the block freezes, raises `done` and reports where the trigger sat in the ring.

A slow processor then reads the record one sample per strobe. Readout starts at the oldest sample and wraps around the ring.

Top module: `ring_acq_top`

## Requirements
- R1: On each valid cycle while acquiring, `samp_lo` is stored at an even ring index and `samp_hi` at the next odd index. The index counts from 0 at arm and wraps at DEPTH, so the sample with ordinal n since arm sits at index n mod DEPTH.
- R2: `trig_src` values 0, 1, 2 and 3 select `trig_in` bits 0, 1, 2 and 3 in that order. The three unselected bits never start the post-trigger phase.
- R3: Let the post-trigger count be N and let pair k hold ordinals 2k and 2k+1. A true selected trigger during pair k counts only if 2k+2 >= DEPTH-N. Earlier true levels are ignored.
- R4: `trig_pos` reports the ring index of the odd (`samp_hi`) sample of the pair in which the trigger counted.
- R5: With trigger ordinal T, the last stored ordinal is S = T+N. `done` rises in the cycle after the pair holding S. If S is even, only `samp_lo` of that pair is written.
- R6: While `done` is high, incoming samples and triggers change neither the stored record nor `trig_pos`.
- R7: When `done` rises, `rd_data` shows the sample at index (S+1) mod DEPTH, which is the oldest. Each `rd_stb` cycle advances one index and wraps at DEPTH. Without a strobe, `rd_data` holds.
- R8: An `arm` cycle clears `done`, reloads the post-trigger count from `post_cnt` (clamped to DEPTH-1), clears the fill count and restarts writing at index 0. Samples offered in the arm cycle itself are dropped.
- R9: After reset, `done` and `trig_pos` are 0. No sample is written and no trigger counts until the first arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, half the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new acquisition |
| post_cnt | input | IDX_W | Samples to store after the trigger sample |
| samp_vld | input | 1 | A sample pair is present this cycle |
| samp_lo | input | DATA_W | Earlier sample of the pair |
| samp_hi | input | DATA_W | Later sample of the pair |
| trig_src | input | SRC_W | Trigger source select |
| trig_in | input | N_SRC | Digital trigger levels, bit 0 channel one, 1 channel two, 2 inter-module, 3 external |
| rd_stb | input | 1 | Advance readout by one sample |
| done | output | 1 | Record complete and frozen |
| trig_pos | output | IDX_W | Ring index of the trigger sample |
| rd_data | output | DATA_W | Sample at the readout position |

## Verification
The internal faults of interest are a slot counter that drifts, a fill count that lets a trigger qualify early, a post-trigger countdown that is off by one, and a final pair that writes its odd half when it should not. Each of these shows up as a `done` that rises in the wrong cycle, or as a `trig_pos` that differs from the trigger ordinal modulo DEPTH. The rest show in the readout. Because the stimulus values equal their ordinals, a wrong oldest slot or a stray overwrite is visible at the very first `rd_data` after `done`. A broken wrap is seen on the strobe that crosses index DEPTH-1. A write that leaks after freezing shows as the filler value in the readout.

// File: rtl/ring_acq_pkg.sv
package ring_acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } acq_st_t;

  // next position on a ring of the given size
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned size);
    return (idx + 1 >= size) ? 0 : idx + 1;
  endfunction

  // trigger may count once the pair being written completes the pre-trigger part
  function automatic bit fill_ok(input int unsigned fill, input int unsigned post,
                                 input int unsigned depth);
    return (fill + 2) >= (depth - post);
  endfunction

  function automatic int unsigned clamp_post(input int unsigned req, input int unsigned depth);
    return (req > depth - 1) ? depth - 1 : req;
  endfunction

endpackage

// File: rtl/ring_bank.sv
module ring_bank #(
  parameter int unsigned W       = 8,
  parameter int unsigned ENTRIES = 4000,
  parameter int unsigned AW      = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/trig_mux.sv
module trig_mux #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);

  logic [N_SRC-1:0] picked;

  for (genvar g = 0; g < N_SRC; g++) begin : g_pick
    assign picked[g] = trig_in[g] && (sel == SEL_W'(g));
  end

  assign hit = |picked;

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import ring_acq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8000,
  parameter int unsigned IDX_W  = 13,
  parameter int unsigned PAIR_W = 12,
  parameter int unsigned FILL_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [IDX_W-1:0]  post_cnt,
  input  logic              samp_vld,
  input  logic              trig_hit,
  input  logic              rd_stb,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic [PAIR_W-1:0] wr_pair,
  output logic              done,
  output logic [IDX_W-1:0]  trig_pos,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              ev_trig,
  output logic              ev_stop
);

  localparam int unsigned HALF = DEPTH / 2;

  acq_st_t              state_q;
  logic [PAIR_W-1:0]    pair_q;
  logic [FILL_W-1:0]    fill_q;
  logic [IDX_W-1:0]     post_q;
  logic [IDX_W-1:0]     remain_q;
  logic [IDX_W-1:0]     tpos_q;
  logic [IDX_W-1:0]     rd_q;
  logic [IDX_W-1:0]     lo_idx;
  logic [IDX_W-1:0]     hi_idx;
  logic [IDX_W-1:0]     stop_idx;

  assign lo_idx = IDX_W'({pair_q, 1'b0});
  assign hi_idx = IDX_W'({pair_q, 1'b1});

  always_comb begin
    wr_lo    = 1'b0;
    wr_hi    = 1'b0;
    ev_trig  = 1'b0;
    ev_stop  = 1'b0;
    stop_idx = '0;
    if (!arm && samp_vld) begin
      case (state_q)
        ST_PRE: begin
          wr_lo = 1'b1;
          wr_hi = 1'b1;
          if (trig_hit && fill_ok(32'(fill_q), 32'(post_q), DEPTH)) begin
            ev_trig = 1'b1;
            if (post_q == '0) begin
              ev_stop  = 1'b1;
              stop_idx = hi_idx;
            end
          end
        end
        ST_POST: begin
          wr_lo = 1'b1;
          if (remain_q == IDX_W'(1)) begin
            ev_stop  = 1'b1;
            stop_idx = lo_idx;
          end else begin
            wr_hi = 1'b1;
            if (remain_q == IDX_W'(2)) begin
              ev_stop  = 1'b1;
              stop_idx = hi_idx;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pair_q   <= '0;
      fill_q   <= '0;
      post_q   <= '0;
      remain_q <= '0;
      tpos_q   <= '0;
      rd_q     <= '0;
    end else if (arm) begin
      state_q  <= ST_PRE;
      pair_q   <= '0;
      fill_q   <= '0;
      post_q   <= IDX_W'(clamp_post(32'(post_cnt), DEPTH));
      remain_q <= '0;
    end else begin
      if (wr_lo) pair_q <= PAIR_W'(wrap_inc(32'(pair_q), HALF));
      if (wr_lo && state_q == ST_PRE && fill_q != FILL_W'(DEPTH))
        fill_q <= fill_q + FILL_W'(2);
      if (ev_trig) begin
        tpos_q   <= hi_idx;
        remain_q <= post_q;
      end
      if (state_q == ST_POST && wr_lo && !ev_stop)
        remain_q <= remain_q - IDX_W'(2);
      if (ev_stop) begin
        state_q <= ST_DONE;
        rd_q    <= IDX_W'(wrap_inc(32'(stop_idx), DEPTH));
      end else if (ev_trig) begin
        state_q <= ST_POST;
      end
      if (state_q == ST_DONE && rd_stb)
        rd_q <= IDX_W'(wrap_inc(32'(rd_q), DEPTH));
    end
  end

  assign wr_pair  = pair_q;
  assign done     = (state_q == ST_DONE);
  assign trig_pos = tpos_q;
  assign rd_idx   = rd_q;

endmodule

// File: rtl/ring_acq_top.sv
module ring_acq_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8000,
  parameter int unsigned N_SRC  = 4,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned SRC_W  = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [IDX_W-1:0]  post_cnt,
  input  logic              samp_vld,
  input  logic [DATA_W-1:0] samp_lo,
  input  logic [DATA_W-1:0] samp_hi,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic [N_SRC-1:0]  trig_in,
  input  logic              rd_stb,
  output logic              done,
  output logic [IDX_W-1:0]  trig_pos,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned HALF   = DEPTH / 2;
  localparam int unsigned PAIR_W = $clog2(HALF);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);

  logic              trig_hit;
  logic              wr_lo;
  logic              wr_hi;
  logic [PAIR_W-1:0] wr_pair;
  logic [IDX_W-1:0]  rd_idx;
  logic              ev_trig;
  logic              ev_stop;
  logic [1:0]        bank_we;
  logic [DATA_W-1:0] bank_wd [2];
  logic [DATA_W-1:0] bank_rd [2];
  logic [PAIR_W-1:0] rd_pair;

  trig_mux #(.N_SRC(N_SRC), .SEL_W(SRC_W)) u_mux (
    .trig_in (trig_in),
    .sel     (trig_src),
    .hit     (trig_hit)
  );

  acq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAIR_W(PAIR_W), .FILL_W(FILL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .post_cnt (post_cnt),
    .samp_vld (samp_vld),
    .trig_hit (trig_hit),
    .rd_stb   (rd_stb),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_pair  (wr_pair),
    .done     (done),
    .trig_pos (trig_pos),
    .rd_idx   (rd_idx),
    .ev_trig  (ev_trig),
    .ev_stop  (ev_stop)
  );

  assign bank_we    = {wr_hi, wr_lo};
  assign bank_wd[0] = samp_lo;
  assign bank_wd[1] = samp_hi;
  assign rd_pair    = PAIR_W'(rd_idx >> 1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ring_bank #(.W(DATA_W), .ENTRIES(HALF), .AW(PAIR_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .waddr (wr_pair),
      .wdata (bank_wd[b]),
      .raddr (rd_pair),
      .rdata (bank_rd[b])
    );
  end

  assign rd_data = bank_rd[rd_idx[0]];

endmodule

// File: rtl/ring_acq_chk.sv
module ring_acq_chk #(
  parameter int unsigned IDX_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             done,
  input logic [IDX_W-1:0] trig_pos,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_stb,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             trig_hit,
  input logic             ev_trig,
  input logic             ev_stop
);

  p_lo_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> wr_lo);

  p_trig_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trig |-> trig_hit);

  p_stop_to_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> done);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(wr_lo || wr_hi));

  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  p_tpos_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> $stable(trig_pos));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm && !rd_stb) |=> $stable(rd_idx));

  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done);

endmodule

bind ring_acq_top ring_acq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arm      (arm),
  .done     (done),
  .trig_pos (trig_pos),
  .rd_idx   (rd_idx),
  .rd_stb   (rd_stb),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .trig_hit (trig_hit),
  .ev_trig  (ev_trig),
  .ev_stop  (ev_stop)
);

// File: tb/ring_acq_top_tb.sv
module ring_acq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int NV         = 6;

  // stimulus: source, post count, first pair with selected trigger high
  localparam int V_SRC  [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int V_POST [NV] = '{0, 5, 15, 8, 7, 1};
  localparam int V_KREQ [NV] = '{0, 3, 0, 10, 2, 20};
  // expected: trigger index, pairs fed until done, last stored ordinal
  localparam int E_POS  [NV] = '{15, 11, 1, 5, 9, 9};
  localparam int E_PAIRS[NV] = '{8, 9, 9, 15, 9, 22};
  localparam int E_STOP [NV] = '{15, 16, 16, 29, 16, 42};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [3:0] post_cnt = '0;
  logic       samp_vld = 1'b0;
  logic [7:0] samp_lo = '0;
  logic [7:0] samp_hi = '0;
  logic [1:0] trig_src = '0;
  logic [3:0] trig_in = '0;
  logic       rd_stb = 1'b0;
  logic       done;
  logic [3:0] trig_pos;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_acq_top #(.DATA_W(8), .DEPTH(DEPTH), .N_SRC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .post_cnt(post_cnt),
    .samp_vld(samp_vld), .samp_lo(samp_lo), .samp_hi(samp_hi),
    .trig_src(trig_src), .trig_in(trig_in), .rd_stb(rd_stb),
    .done(done), .trig_pos(trig_pos), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int post);
    @(negedge clk);
    arm = 1'b1; post_cnt = 4'(post); samp_vld = 1'b1;
    @(negedge clk);
    arm = 1'b0; samp_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pairs;
    logic [3:0] sel1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 done after reset", int'(done), 0);
    chk("R9 trig_pos after reset", int'(trig_pos), 0);

    // R9: before any arm, triggers and samples do nothing
    for (int k = 0; k < 20; k++) begin
      samp_vld = 1'b1; samp_lo = 8'hAA; samp_hi = 8'hBB; trig_in = 4'hF;
      @(negedge clk);
    end
    samp_vld = 1'b0; trig_in = '0;
    chk("R9 no capture before arm", int'(done), 0);

    // table of vectors covering R1..R5
    for (int v = 0; v < NV; v++) begin
      trig_src = 2'(V_SRC[v]);
      sel1 = 4'b1 << V_SRC[v];
      trig_in = '0;
      do_arm(V_POST[v]);
      chk("R8 done cleared by arm", int'(done), 0);
      pairs = 0;
      while (!done && pairs < 60) begin
        samp_vld = 1'b1;
        samp_lo = 8'(2*pairs);
        samp_hi = 8'(2*pairs + 1);
        trig_in = (pairs >= V_KREQ[v]) ? 4'hF : ~sel1;
        @(negedge clk);
        pairs++;
      end
      samp_vld = 1'b0;
      chk("R3 R5 pairs until done", pairs, E_PAIRS[v]);
      chk("R2 R4 trig_pos", int'(trig_pos), E_POS[v]);
      // R6: record frozen after done
      for (int k = 0; k < 3; k++) begin
        samp_vld = 1'b1; samp_lo = 8'hEE; samp_hi = 8'hEE; trig_in = 4'hF;
        @(negedge clk);
      end
      samp_vld = 1'b0; trig_in = '0;
      chk("R6 done held", int'(done), 1);
      chk("R6 trig_pos held", int'(trig_pos), E_POS[v]);
      // R1 R7: oldest first, sequential, wrapping
      for (int j = 0; j < DEPTH; j++) begin
        chk("R1 R5 R7 readout", int'(rd_data), (E_STOP[v] - (DEPTH-1) + j) & 255);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
      end
      chk("R7 readout wraps", int'(rd_data), (E_STOP[v] - (DEPTH-1)) & 255);
    end

    // R7: no strobe, data holds
    repeat (4) @(negedge clk);
    chk("R7 hold without strobe", int'(rd_data), (E_STOP[NV-1] - (DEPTH-1)) & 255);

    // R8: rearm clears done
    do_arm(3);
    chk("R8 rearm clears done", int'(done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule